// File: doc/BRIEF.md
# Loop Port Bypass Controller

This block decides, for each of two arbitrated-loop ports, whether the device should be switched out of the loop by the external bypass circuit that sits on that port. For each port it drives an active-low bypass request and an active-low indicator drive. The indicator always follows the request.

A port enters bypass when its upstream decoder reports a loop port bypass primitive sequence. Both ports enter bypass when any hardware failure is flagged: a wrap test failure, a loss of receive clock, a loss of transmit clock, or an interface error. A port leaves bypass only on a loop port enable primitive sequence, and only while self-test has completed and no failure has been seen since reset. Failure flags are latched until reset, so a brief clock loss keeps the device out of the loop for good. Receive-side inputs are still acted on while a port is bypassed, which is what allows a later enable primitive to bring the port back.

All decisions are registered. An output changes on the clock edge that follows the cycle in which its cause is presented.

Top module: `loop_bypass_ctrl`

## Requirements
- R1: After reset, both bypass requests (`byp_n`) and both indicator drives (`led_n`) are low, meaning bypassed.
- R2: Each `led_n` bit equals the `byp_n` bit of the same port at all times.
- R3: A pulse on `byp_prim[p]` drives `byp_n[p]` low on the next clock edge and leaves the other port unchanged.
- R4: A pulse on `ena_prim[p]`, with `selftest_done` high and no failure seen since reset, drives `byp_n[p]` high on the next clock edge. This holds even while port p is bypassed.
- R5: An enable primitive presented while `selftest_done` is low has no effect.
- R6: If any of `fail_wrap`, `fail_rxclk`, `fail_txclk` or `fail_intf` is high in a cycle, both `byp_n` bits are low after the next clock edge.
- R7: A failure is remembered until reset. After a failure, even a one-cycle one, enable primitives are ignored and both ports stay bypassed.
- R8: When `byp_prim[p]` and `ena_prim[p]` are high in the same cycle, port p ends up bypassed.
- R9: With no primitive and no failure, each port holds its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byp_prim | input | 2 | Per-port pulse: bypass primitive sequence seen (bit 0 = port 0) |
| ena_prim | input | 2 | Per-port pulse: enable primitive sequence seen |
| selftest_done | input | 1 | Self-test has completed |
| fail_wrap | input | 1 | Wrap test failure |
| fail_rxclk | input | 1 | Receive clock lost |
| fail_txclk | input | 1 | Transmit clock lost |
| fail_intf | input | 1 | Interface hardware error |
| byp_n | output | 2 | Active-low bypass request per port |
| led_n | output | 2 | Active-low bypass indicator drive per port |

## Verification
The state consists of one bypass bit per port and one latched-failure bit, and all of them appear at the ports one edge after their cause.

A per-port bit that is stuck or wrongly set shows up within one cycle of the next primitive. It shows as a port that fails to drop out, fails to rejoin, or disturbs its neighbour.

A latched-failure bit that never sets, or that clears itself, shows up at the first enable primitive after the fault pulse. In that case a port rejoins the loop when it should not. Such a fault is visible only if an enable is applied after the failure flag has dropped, so the bench does exactly that for every one of the four flags.

// File: rtl/loop_bypass_ctrl.sv
module loop_bypass_ctrl #(
  parameter int NPORTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] byp_prim,
  input  logic [NPORTS-1:0] ena_prim,
  input  logic              selftest_done,
  input  logic              fail_wrap,
  input  logic              fail_rxclk,
  input  logic              fail_txclk,
  input  logic              fail_intf,
  output logic [NPORTS-1:0] byp_n,
  output logic [NPORTS-1:0] led_n
);

  logic              fail_now;
  logic              fail_seen;
  logic              fault;
  logic [NPORTS-1:0] bypassed;

  assign fail_now = fail_wrap | fail_rxclk | fail_txclk | fail_intf;
  assign fault    = fail_now | fail_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_seen <= 1'b0;
    else if (fail_now) fail_seen <= 1'b1;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bypassed[p] <= 1'b1;
      else if (fault || byp_prim[p])
        bypassed[p] <= 1'b1;
      else if (ena_prim[p] && selftest_done)
        bypassed[p] <= 1'b0;
    end

    p_byp_prim_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byp_prim[p] |=> !byp_n[p]);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_prim[p] && !byp_prim[p] && selftest_done && !fail_now && !fail_seen) |=> byp_n[p]);

    p_no_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !selftest_done |=> !$rose(byp_n[p]));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_prim[p] && !ena_prim[p] && !fail_now) |=> $stable(byp_n[p]));
  end

  p_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_now |=> (byp_n == '0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_seen |-> (byp_n == '0));

  assign byp_n = ~bypassed;
  assign led_n = ~bypassed;

endmodule

// File: tb/loop_bypass_ctrl_tb.sv
module loop_bypass_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] byp_prim = '0;
  logic [1:0] ena_prim = '0;
  logic       selftest_done = 1'b0;
  logic       fail_wrap = 1'b0;
  logic       fail_rxclk = 1'b0;
  logic       fail_txclk = 1'b0;
  logic       fail_intf = 1'b0;
  logic [1:0] byp_n;
  logic [1:0] led_n;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  loop_bypass_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .byp_prim(byp_prim), .ena_prim(ena_prim),
    .selftest_done(selftest_done), .fail_wrap(fail_wrap), .fail_rxclk(fail_rxclk),
    .fail_txclk(fail_txclk), .fail_intf(fail_intf), .byp_n(byp_n), .led_n(led_n)
  );

  // {byp_prim[1:0], ena_prim[1:0], done, fail{intf,txclk,rxclk,wrap}, expected byp_n[1:0]}
  localparam int NV = 11;
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 2'b00, 1'b0, 4'b0000, 2'b00},  // R9 hold after reset
    {2'b00, 2'b11, 1'b0, 4'b0000, 2'b00},  // R5 enable without self-test
    {2'b00, 2'b01, 1'b1, 4'b0000, 2'b01},  // R4 release port 0
    {2'b00, 2'b10, 1'b1, 4'b0000, 2'b11},  // R4 release port 1
    {2'b00, 2'b00, 1'b1, 4'b0000, 2'b11},  // R9 hold released
    {2'b01, 2'b00, 1'b1, 4'b0000, 2'b10},  // R3 bypass port 0 only
    {2'b10, 2'b01, 1'b1, 4'b0000, 2'b01},  // R3 R4 opposite actions per port
    {2'b11, 2'b11, 1'b1, 4'b0000, 2'b00},  // R8 bypass wins
    {2'b00, 2'b11, 1'b1, 4'b0000, 2'b11},  // R4 both released
    {2'b00, 2'b00, 1'b1, 4'b0001, 2'b00},  // R6 wrap failure
    {2'b00, 2'b11, 1'b1, 4'b0000, 2'b00}   // R7 sticky
  };

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (byp_n !== exp) begin
      fails++;
      $display("FAIL %s byp_n actual=%b expected=%b", req, byp_n, exp);
    end
    checks++;
    if (led_n !== exp) begin
      fails++;
      $display("FAIL R2 (%s) led_n actual=%b expected=%b", req, led_n, exp);
    end
  endtask

  task automatic apply(input logic [1:0] b, input logic [1:0] e, input logic d, input logic [3:0] f);
    @(negedge clk);
    byp_prim = b; ena_prim = e; selftest_done = d;
    {fail_intf, fail_txclk, fail_rxclk, fail_wrap} = f;
    @(negedge clk);
    byp_prim = '0; ena_prim = '0;
    {fail_intf, fail_txclk, fail_rxclk, fail_wrap} = 4'b0000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    selftest_done = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'b00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][10:9], VEC[i][8:7], VEC[i][6], VEC[i][5:2]);
      check($sformatf("vector %0d", i), VEC[i][1:0]);
    end

    do_reset();
    check("R1", 2'b00);

    for (int k = 0; k < 4; k++) begin
      do_reset();
      apply(2'b00, 2'b11, 1'b1, 4'b0000);
      check("R4", 2'b11);
      apply(2'b00, 2'b00, 1'b1, 4'b0001 << k);
      check($sformatf("R6 flag %0d", k), 2'b00);
      apply(2'b00, 2'b11, 1'b1, 4'b0000);
      check($sformatf("R7 flag %0d", k), 2'b00);
      apply(2'b00, 2'b00, 1'b1, 4'b0000);
      check("R7 hold", 2'b00);
    end

    do_reset();
    apply(2'b00, 2'b10, 1'b1, 4'b0000);
    check("R4 port1 only", 2'b10);
    apply(2'b10, 2'b10, 1'b1, 4'b0000);
    check("R8 port1", 2'b00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule